// File: doc/BRIEF.md
# Preset-Reload Programmable Frequency Divider

This block divides its clock by a ratio set through a 16-bit preset word. The count is held in four 4-bit binary stages. Each stage's carry enables the stage above it. The counter starts at the preset and counts up to all-ones. On the clock edge after it reaches all-ones it reloads the preset instead of wrapping to zero. With the enable held high, one period therefore lasts 65536 minus the preset clocks. To get a ratio N, the preset is set to 65536 − N. For example, a preset of 0x63C0 divides by 40,000 and a preset of 0xC2C0 divides by 15,680.

Two signals mark each period:
- The terminal-count pulse is high for one clock per period.
- The divided output is a square wave driven by a two-state machine with states OUT_LOW and OUT_HIGH. The only transition is TOGGLE, taken on every terminal count: OUT_LOW→OUT_HIGH or OUT_HIGH→OUT_LOW. Without a terminal count the machine takes HOLD and keeps its state.

Reset is synchronous. It loads the preset directly, so the first period after reset already has its full length. Outside reset, the preset is only sampled at reload, so a new preset takes effect from the following period.

Top module: `prdiv_top`

## Requirements
- R1: While rst is high at a rising edge, count loads preset and the divided-output machine enters OUT_LOW (div_out = 0). Counting resumes from that value once rst falls.
- R2: With en high and count not equal to 0xFFFF, count increases by exactly one at the next edge. The carry crosses nibble boundaries, for example 0x00FF becomes 0x0100.
- R3: With en low, count and div_out keep their values and tc stays 0.
- R4: tc is 1 exactly when en is 1 and count is 0xFFFF. It is combinational in the same cycle.
- R5: At an edge where tc is 1, count takes the value of preset present at that edge.
- R6: With en held high, tc pulses once every 65536 − P clocks. A preset of 0xFFF6 gives 10, 0x63C0 gives 40000 and 0xC2C0 gives 15680.
- R7: A preset change made between reloads does not alter the current period. The old period length is kept until the next reload.
- R8: div_out toggles (transition TOGGLE) at each edge where tc is 1 and holds (transition HOLD) otherwise. Its period is therefore twice the division ratio.
- R9: With preset 0xFFFF and en high, tc is 1 on every cycle and count stays 0xFFFF (ratio 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; loads the preset |
| en | input | 1 | Count enable into the lowest stage |
| preset | input | 16 | Reload value; ratio is 65536 minus this value |
| count | output | 16 | Current count value |
| tc | output | 1 | Terminal-count pulse, one clock per period |
| div_out | output | 1 | Toggled divided output |

## Verification
The properties assume that rst, en and preset are stable around each rising edge. The bench drives all three on the falling edge to keep that assumption true.

The reload property compares the new count with preset as sampled at the reload edge. Because of that, preset may change at any cycle, and the stimulus does change it mid-period.

All properties are switched off while rst is high, except the one check made in the first cycle after release. That check expects the preset sampled during the last reset edge.

// File: rtl/prdiv_pkg.sv
package prdiv_pkg;

    // Divided-output machine states
    typedef enum logic [0:0] {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_t;

endpackage

// File: rtl/prdiv_stage.sv
// One binary counter slice with synchronous parallel load and ripple-free carry.
module prdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load,
    input  logic         cin,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         cout
);

    always_ff @(posedge clk) begin
        if (load) begin
            q <= d;
        end else if (cin) begin
            q <= q + 1'b1;
        end
    end

    // Carry out only when enabled and this slice is saturated
    assign cout = cin & (&q);

endmodule

// File: rtl/prdiv_outfsm.sv
// Two-state machine producing the divided square wave.
module prdiv_outfsm
    import prdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    output logic out
);

    out_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: TOGGLE on terminal count, HOLD otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW:  if (toggle) state_d = OUT_HIGH;
            OUT_HIGH: if (toggle) state_d = OUT_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_LOW:  out = 1'b0;
            OUT_HIGH: out = 1'b1;
        endcase
    end

endmodule

// File: rtl/prdiv_top.sv
module prdiv_top #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [STAGE_W*STAGES-1:0]  preset,
    output logic [STAGE_W*STAGES-1:0]  count,
    output logic                       tc,
    output logic                       div_out
);

    localparam int CNT_W = STAGE_W * STAGES;

    logic [STAGES:0] carry;
    logic            reload;

    assign carry[0] = en;
    assign tc       = carry[STAGES];
    assign reload   = rst | tc;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            prdiv_stage #(.W(STAGE_W)) u_stage (
                .clk  (clk),
                .load (reload),
                .cin  (carry[i]),
                .d    (preset[i*STAGE_W +: STAGE_W]),
                .q    (count[i*STAGE_W +: STAGE_W]),
                .cout (carry[i+1])
            );
        end
    endgenerate

    prdiv_outfsm u_out (
        .clk    (clk),
        .rst    (rst),
        .toggle (tc),
        .out    (div_out)
    );

    logic unused_w;
    assign unused_w = (CNT_W == 0);

endmodule

// File: rtl/prdiv_chk.sv
module prdiv_chk #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      en,
    input logic [STAGE_W*STAGES-1:0] preset,
    input logic [STAGE_W*STAGES-1:0] count,
    input logic                      tc,
    input logic                      div_out
);

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == $past(preset) && !div_out));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tc) |=> count == $past(count) + 1'b1);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(count) && $stable(div_out)));

    // R4
    tc_only_at_top_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> (en && (&count)));

    // R4
    tc_when_top_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (&count)) |-> tc);

    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> count == $past(preset));

    // R8
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> div_out != $past(div_out));

    // R8
    no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !tc |=> $stable(div_out));

endmodule

bind prdiv_top prdiv_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .preset  (preset),
    .count   (count),
    .tc      (tc),
    .div_out (div_out)
);

// File: tb/sim_prdiv_top.sv
`timescale 1ns/1ps
module sim_prdiv_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] preset = 16'h0000;
    logic [15:0] count;
    logic        tc;
    logic        div_out;

    always #2 clk = ~clk;

    prdiv_top u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .preset  (preset),
        .count   (count),
        .tc      (tc),
        .div_out (div_out)
    );

    int nvec = 0;
    int nbad = 0;
    int cyc = 0;
    int last_tc = -1;
    int periods[$];
    int ref_cnt;
    bit ref_div;
    bit mvalid = 0;
    bit prev_rst, prev_en, prev_tc;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then apply new inputs
    task automatic step(input logic r, input logic e, input logic [15:0] p);
        string rq;
        bit    tc_exp;
        @(negedge clk);
        cyc++;
        if (mvalid) begin
            rq = prev_rst ? "R1" : (prev_tc ? "R5" : (prev_en ? "R2" : "R3"));
            chk(rq, 32'(count), 32'(ref_cnt));
            tc_exp = (ref_cnt == 16'hFFFF) && en;
            chk("R4", 32'(tc), 32'(tc_exp));
            chk("R8", 32'(div_out), 32'(ref_div));
            if (tc_exp && !rst) begin
                if (last_tc >= 0) periods.push_back(cyc - last_tc);
                last_tc = cyc;
            end
        end
        rst = r;
        en = e;
        preset = p;
        prev_rst = r;
        prev_en = e;
        prev_tc = mvalid && e && (ref_cnt == 16'hFFFF);
        if (r) begin
            ref_cnt = int'(p);
            ref_div = 1'b0;
            mvalid = 1'b1;
            last_tc = -1;
            periods.delete();
        end else if (mvalid && e) begin
            if (ref_cnt == 16'hFFFF) begin
                ref_cnt = int'(p);
                ref_div = ~ref_div;
            end else begin
                ref_cnt = ref_cnt + 1;
            end
        end
    endtask

    task automatic run(input int n, input logic [15:0] p);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, p);
    endtask

    initial begin
        logic [15:0] held;
        logic        held_div;

        // R1 / R6: short ratio 10
        step(1'b1, 1'b0, 16'hFFF6);
        step(1'b1, 1'b0, 16'hFFF6);
        step(1'b0, 1'b1, 16'hFFF6);
        chk("R1", 32'(count), 32'hFFF6);
        chk("R1", 32'(div_out), 32'h0);
        run(25, 16'hFFF6);
        chk("R6", 32'(periods.size() > 0 ? periods[0] : -1), 32'd10);

        // R3: hold with enable low
        step(1'b0, 1'b0, 16'hFFF6);
        held = count;
        held_div = div_out;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 16'h1234);
        chk("R3", 32'(count), 32'(held));
        chk("R3", 32'(div_out), 32'(held_div));
        chk("R3", 32'(tc), 32'h0);

        // R2: carry across nibbles
        step(1'b1, 1'b0, 16'h00FE);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'h00FE);
        chk("R2", 32'(count), 32'h0100);

        // R7 / R5: preset changed mid-period
        step(1'b1, 1'b0, 16'hFFF0);
        run(40, 16'hFFF0);
        run(40, 16'hFFF8);
        chk("R7", 32'(periods.size() > 1 ? periods[1] : -1), 32'd16);
        chk("R5", 32'(periods.size() > 2 ? periods[2] : -1), 32'd8);
        chk("R8", 32'(periods.size() > 3 ? periods[3] : -1), 32'd8);

        // R9: ratio one
        step(1'b1, 1'b0, 16'hFFFF);
        step(1'b0, 1'b1, 16'hFFFF);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 16'hFFFF);
            chk("R9", 32'(tc), 32'h1);
            chk("R9", 32'(count), 32'hFFFF);
        end

        // R6: large ratios
        step(1'b1, 1'b0, 16'h63C0);
        run(80002, 16'h63C0);
        chk("R6", 32'(periods.size() > 0 ? periods[0] : -1), 32'd40000);
        step(1'b1, 1'b0, 16'hC2C0);
        run(31362, 16'hC2C0);
        chk("R6", 32'(periods.size() > 0 ? periods[0] : -1), 32'd15680);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule